// File: doc/BRIEF.md
# Serial Flash Status Read Responder

This block is the device-side answer to the status-read command of a serial memory with an SPI-style port. While chip select is low it collects an 8-bit command on the serial input, most significant bit first. If the command is the status-read code, it returns the status byte on the serial output and keeps sending it for as long as select stays low. If the command is anything else, the output stays silent.

The status byte carries two live flags. The busy flag follows an external signal from the program and erase sequencer. The write-enable latch is set and cleared by two pulse inputs. The latch is also driven out as a permission signal that tells the rest of the device whether a modifying command may be taken. The status read is always answered, even while the sequencer is busy. A host can therefore poll in one long transfer and watch the busy flag drop.

The SPI pins are oversampled by a fast system clock. The serial output is not a tri-state pin. It is a data/enable pair, so the pad or a parent module builds the high-impedance buffer.

Top module: `spi_status_responder`

## Requirements
- R1: The command byte is taken from `spi_mosi` on the first eight rising `spi_sclk` edges after `spi_cs_n` falls, most significant bit first. The value 8'h05 selects the status read.
- R2: `spi_miso_oe` is 0 for the whole command phase. After the falling `spi_sclk` edge that follows the 8th rising edge, `spi_miso_oe` is 1 and `spi_miso` carries status bit 7.
- R3: Status bits leave on falling `spi_sclk` edges in the order bit 7, 6, … 0, so the host can sample each one on the next rising edge.
- R4: While `spi_cs_n` stays low, the status byte is sent again directly after bit 0, with no idle clock between bytes.
- R5: Each byte is a fresh snapshot of the status, taken at the falling edge that starts the byte. A change made during one byte therefore shows in the next byte.
- R6: Status bit 0 is the busy flag, a registered copy of `busy_in`. The status read is served whatever its value.
- R7: Status bit 1 is the write-enable latch. `wel_set` sets it, `wel_clr` clears it, and `wel_clr` wins when both are high. It is 0 after reset.
- R8: Status bits 7 down to 2 always read 0.
- R9: `write_permit` equals the write-enable latch.
- R10: Raising `spi_cs_n` at any point ends the transfer. `spi_miso_oe` drops within 4 system clocks, and the next transfer starts again with a fresh command phase.
- R11: Any command other than 8'h05 keeps `spi_miso_oe` at 0 until `spi_cs_n` rises.
- R12: After `rst`, `spi_miso_oe` is 0 and `write_permit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low (mode 0) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| busy_in | input | 1 | High while a program/erase cycle runs |
| wel_set | input | 1 | Pulse that sets the write-enable latch |
| wel_clr | input | 1 | Pulse that clears the write-enable latch |
| spi_miso | output | 1 | Serial status data to the host |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso`; 0 means high impedance |
| write_permit | output | 1 | 1 when modifying commands may be accepted |

## Verification
The assertions assume two things about the inputs. First, `spi_sclk` is slow next to `clk`, so every SPI level is held for several system clocks and edges arrive in the synchronized order. Second, `spi_cs_n` only changes while `spi_sclk` is low. The stimulus holds each half serial period for 8 system clocks. It moves select only with the serial clock low, and it changes `busy_in` and pulses the latch inputs only while the serial clock is high in the middle of a byte. This places every status change clearly before the next byte boundary. Random commands, byte counts, early aborts and flag changes come from a seeded `$urandom`. Directed cases cover a busy flag that falls during a continuous read, a set/clear collision, a wrong command code and an abort in the middle of a byte.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_STREAM = 2'd1,
    PH_MUTE   = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_stat_reg.sv
module spi_stat_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         busy_in,
  input  logic         wel_set,
  input  logic         wel_clr,
  output logic [W-1:0] stat,
  output logic         write_permit
);
  logic wip_q, wel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wip_q <= 1'b0;
      wel_q <= 1'b0;
    end else begin
      wip_q <= busy_in;
      if (wel_clr)      wel_q <= 1'b0;
      else if (wel_set) wel_q <= 1'b1;
    end
  end

  always_comb begin
    stat    = '0;
    stat[0] = wip_q;
    stat[1] = wel_q;
  end

  assign write_permit = wel_q;

  // R7
  wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wel_clr |=> !write_permit);
  // R7
  wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wel_set && !wel_clr) |=> write_permit);
  // R6
  wip_follow_chk: assert property (@(posedge clk) disable iff (rst)
    busy_in |=> stat[0]);
  // R6
  wip_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_in |=> !stat[0]);
endmodule

// File: rtl/spi_stat_shifter.sv
module spi_stat_shifter
  import spi_stat_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] CMD_CODE = 8'h05
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         cs_n_s,
  input  logic         mosi_s,
  input  logic [W-1:0] stat,
  output logic         miso,
  output logic         miso_oe
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W-1);

  phase_t        phase;
  logic          sclk_d;
  logic [CW-1:0] cnt;
  logic [W-1:0]  cmd_sr, snap;
  logic          rise, fall;
  logic [W-1:0]  cmd_next;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign cmd_next = {cmd_sr[W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      phase   <= PH_CMD;
      cnt     <= '0;
      cmd_sr  <= '0;
      snap    <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      unique case (phase)
        PH_CMD: if (rise) begin
          cmd_sr <= cmd_next;
          if (cnt == LAST) begin
            cnt   <= '0;
            phase <= (cmd_next == CMD_CODE) ? PH_STREAM : PH_MUTE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_STREAM: if (fall) begin
          miso_oe <= 1'b1;
          if (cnt == '0) begin
            snap <= stat;
            miso <= stat[W-1];
          end else begin
            miso <= snap[LAST - cnt];
          end
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R10
  cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso_oe);
  // R2
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CMD) |-> !miso_oe);
  // R11
  mute_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MUTE) |-> !miso_oe);
  // R4
  stream_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (miso_oe && !cs_n_s) |=> miso_oe);
  // R1
  cmd_len_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CMD && rise && cnt == LAST && !cs_n_s) |=> phase != PH_CMD);
endmodule

// File: rtl/spi_status_responder.sv
module spi_status_responder #(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [W-1:0] CMD_CODE = 8'h05
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic busy_in,
  input  logic wel_set,
  input  logic wel_clr,
  output logic spi_miso,
  output logic spi_miso_oe,
  output logic write_permit
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pins_s;
  logic [W-1:0]    stat;

  spi_pin_sync #(
    .W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_mosi, spi_cs_n, spi_sclk}),
    .q(pins_s)
  );

  spi_stat_reg #(.W(W)) u_stat (
    .clk(clk), .rst(rst),
    .busy_in(busy_in), .wel_set(wel_set), .wel_clr(wel_clr),
    .stat(stat), .write_permit(write_permit)
  );

  spi_stat_shifter #(.W(W), .CMD_CODE(CMD_CODE)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[0]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[2]),
    .stat(stat),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );
endmodule

// File: tb/tb_spi_status_responder.sv
module tb_spi_status_responder;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic busy = 1'b0, wset = 1'b0, wclr = 1'b0;
  logic miso, oe, permit;
  logic wel_m = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  spi_status_responder dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .busy_in(busy), .wel_set(wset), .wel_clr(wclr),
    .spi_miso(miso), .spi_miso_oe(oe), .write_permit(permit)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] exp_stat(input logic b, input logic w);
    return {6'b0, w, b};  // R6 R7 R8
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic sys(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wel_pulse(input logic s, input logic c);
    wset = s; wclr = c;
    sys(1);
    wset = 0; wclr = 0;
    if (c) wel_m = 0; else if (s) wel_m = 1;
  endtask

  // ev: 0 none, 1 toggle busy, 2 set wel, 3 clear wel, 4 set+clear
  task automatic apply_event(input int ev);
    case (ev)
      1: busy = ~busy;
      2: wel_pulse(1, 0);
      3: wel_pulse(0, 1);
      4: wel_pulse(1, 1);
      default: ;
    endcase
  endtask

  task automatic transfer(input logic [7:0] op, input int nbytes, input int abort_bit,
                          input int ev_byte, input int ev);
    logic [7:0] got, expb;
    bit oe_ok;
    bit is_rd = (op == 8'h05);
    cs_n = 0;
    sys(HALF);
    oe_ok = 1;
    for (int i = 0; i < 8; i++) begin
      mosi = op[7-i];
      sys(HALF);
      if (oe) oe_ok = 0;
      sclk = 1; sys(HALF); sclk = 0;
    end
    chk(oe_ok, "R2 oe low in command phase", 0, 0);
    for (int b = 0; b < nbytes; b++) begin
      expb = exp_stat(busy, wel_m);
      got = '0; oe_ok = 1;
      for (int k = 0; k < 8; k++) begin
        sys(HALF);
        if (b == 0 && k == abort_bit) begin
          cs_n = 1;
          sys(6);
          chk(!oe, "R10 abort mid-byte drops oe", oe, 0);
          return;
        end
        if (oe !== is_rd) oe_ok = 0;
        got[7-k] = miso;
        sclk = 1;
        sys(3);
        if (k == 3 && b == ev_byte) begin
          apply_event(ev);
          sys(2);
          chk(permit == wel_m, "R9 permit follows latch", permit, wel_m);
        end else sys(2);
        sys(HALF - 5);
        sclk = 0;
      end
      if (is_rd) begin
        chk(oe_ok, "R2 R4 oe held through stream", 0, 0);
        chk(got == expb, "R3 R5 status byte", got, expb);
      end else
        chk(oe_ok, "R11 unknown command stays silent", 0, 0);
    end
    sys(HALF);
    cs_n = 1;
    sys(6);
    chk(!oe, "R10 select rise drops oe", oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = $urandom(1234);
    sys(4);
    rst = 0;
    sys(2);
    chk(!oe, "R12 oe after reset", oe, 0);
    chk(!permit, "R12 permit after reset", permit, 0);
    // R1 R6: read while busy, busy falls during byte 1 (seen in byte 2)
    busy = 1;
    sys(4);
    transfer(8'h05, 3, -1, 1, 1);
    // R7: set, then collision where clear wins
    transfer(8'h05, 2, -1, 0, 2);
    transfer(8'h05, 2, -1, 0, 4);
    // R11: wrong code
    transfer(8'h06, 2, -1, -1, 0);
    // R10: abort mid-byte, then clean restart
    wel_pulse(1, 0);
    transfer(8'h05, 2, 4, -1, 0);
    transfer(8'h05, 2, -1, -1, 0);
    for (int t = 0; t < 40; t++) begin
      logic [7:0] op;
      int nb, ab, evb, ev;
      op  = ($urandom % 4 != 0) ? 8'h05 : 8'($urandom);
      if ($urandom % 4 == 0 && op == 8'h05) op = 8'hA5;
      nb  = 1 + $urandom % 4;
      ab  = ($urandom % 5 == 0) ? int'($urandom % 8) : -1;
      evb = $urandom % nb;
      ev  = $urandom % 5;
      transfer(op, nb, ab, evb, ev);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule